// File: doc/BRIEF.md
# System Control Register Block with Self-Timed Soft Resets

This block is a small system-controller register file on a 32-bit read/write bus. Software reaches four registers through it. The first is a soft-reset register. Each bit of it starts a reset pulse of fixed length on its own output line, and the pulse ends without any further write. The second is a clock-control register: its low field holds per-peripheral clock gates, and its upper fields hold clock option selects. The third is a misc-control register that picks the PCI bus clock speed. The fourth is a read-only status word that shows the board strap pins.

Writes take effect on the clock edge at which the bus write strobe is sampled. Read data is registered, so it appears one cycle after the read strobe. Offsets that no register decodes read as zero and ignore writes. The gate outputs use set-to-disable polarity: a stored 1 stops the clock. After reset, every gate is open, and that includes the memory-controller gate and the flash gate.

Top module: `sys_ctl_regs`

## Requirements
- R1: During and after a synchronous reset, the following are all 0: every reset line, every gate-off output, the clock-run enable, the TV half-divider, the security select, the fast-PCI select and the read data. Reset cancels any pulse that is in progress.
- R2: A write to offset 0x0C raises every line whose data bit is 1 on the edge that takes the write. Each such line stays high for exactly PULSE_LEN cycles (default 16) and then drops. Lines whose data bit is 0 do not change.
- R3: Writing 1 again to a line that is already pulsing restarts its count, so the line stays high for PULSE_LEN cycles counted from the newer write.
- R4: Writing 0 to a line at offset 0x0C neither ends nor lengthens a pulse that is in progress. No deassert action exists.
- R5: A read of offset 0x0C returns a 1 in bit i for every line i that is still pulsing at the read edge.
- R6: Bit 30 of offset 0x0C is the second-processor reset line. A write with bit 30 set and other bits clear starts a pulse on line 30 only, and running pulses on the other lines continue unchanged.
- R7: Bits 13..1 of the clock-control register at offset 0x34 drive gate_off[12:0]. A 1 gates the clock off, and any bit can be both written and read back.
- R8: In the clock-control register, bit 16 is the clock-run enable, bits 28..24 are the TV half-divider, and bit 29 selects the full-rate security clock (1) or the three-quarter-rate clock (0). All other bits read back as 0.
- R9: Bit 18 of the misc-control register at offset 0x30 selects the fast PCI clock (1 = 66 MHz, 0 = 33 MHz). All other bits read back as 0.
- R10: Offset 0x04 reads the strap levels captured while reset was high. The crystal strap is in bit 30, the AHB speed strap in bits 17..15 and the CPU:AHB ratio strap in bits 19..18. Writes to this offset, and later strap changes, do not change the value read.
- R11: A read of any offset other than 0x04, 0x0C, 0x30 or 0x34 (misaligned offsets included) returns 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| strap_xtal_half | input | 1 | Crystal select strap |
| strap_ahb_speed | input | 3 | AHB speed strap |
| strap_cpu_ratio | input | 2 | CPU:AHB ratio strap |
| srst_out | output | NUM_RST | Self-clearing reset lines |
| gate_off | output | 13 | Clock gate controls, 1 = clock stopped |
| clkrun_en | output | 1 | PCI clock-run enable |
| tv_half_div | output | 5 | TV half-divider value |
| sec_clk_full | output | 1 | Security clock full rate select |
| pci_clk_fast | output | 1 | Fast PCI clock select |

## Verification
Register outputs and reset lines change on the edge that samples the write. Read data comes one edge after the read strobe. A reset line falls on the edge that comes PULSE_LEN edges after its last starting write. The bench drives every stimulus at a falling edge and samples at the next falling edge. Pulse lengths are measured by counting falling-edge observations while the line stays high. Every expected length is worked out from the edge on which the write or read was taken, so restarts and zero-writes show up as a count that is exactly right or wrong by whole cycles.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DATA_W = 32;

  // register byte offsets
  localparam int unsigned OFS_STATUS = 32'h04;
  localparam int unsigned OFS_SRST   = 32'h0C;
  localparam int unsigned OFS_MISC   = 32'h30;
  localparam int unsigned OFS_CLK    = 32'h34;

  // clock-control fields
  localparam int unsigned GATE_LSB   = 1;
  localparam int unsigned GATE_NUM   = 13;
  localparam int unsigned CLKRUN_BIT = 16;
  localparam int unsigned TVDIV_LSB  = 24;
  localparam int unsigned TVDIV_W    = 5;
  localparam int unsigned SECSEL_BIT = 29;

  // misc-control field
  localparam int unsigned PCI66_BIT  = 18;

  // status fields
  localparam int unsigned ST_XTAL_BIT  = 30;
  localparam int unsigned ST_AHB_LSB   = 15;
  localparam int unsigned ST_AHB_W     = 3;
  localparam int unsigned ST_RATIO_LSB = 18;
  localparam int unsigned ST_RATIO_W   = 2;

  // second-processor reset line
  localparam int unsigned CPU1_RST_BIT = 30;

  function automatic logic [DATA_W-1:0] field_mask(input int unsigned lsb, input int unsigned w);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < DATA_W; i++)
      if (i >= lsb && i < lsb + w) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CLK_MASK =
    field_mask(GATE_LSB, GATE_NUM) | field_mask(CLKRUN_BIT, 1) |
    field_mask(TVDIV_LSB, TVDIV_W) | field_mask(SECSEL_BIT, 1);
  localparam logic [DATA_W-1:0] MISC_MASK = field_mask(PCI66_BIT, 1);
endpackage

// File: rtl/srst_pulse_ctr.sv
module srst_pulse_ctr #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  localparam int unsigned CW = (PULSE_LEN < 2) ? 1 : $clog2(PULSE_LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start) begin
      cnt_q <= CW'(PULSE_LEN);
      act_q <= 1'b1;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      act_q <= (cnt_q > CW'(1));
    end
  end

  assign active = act_q;
endmodule

// File: rtl/masked_ctl_reg.sv
module masked_ctl_reg #(
  parameter int unsigned         W        = 32,
  parameter logic [W-1:0]        MASK     = '1,
  parameter logic [W-1:0]        RST_VAL  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)     q_r <= RST_VAL & MASK;
    else if (we) q_r <= wdata & MASK;
  end

  assign q = q_r;
endmodule

// File: rtl/strap_status.sv
module strap_status
  import sysctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  xtal_half,
  input  logic [ST_AHB_W-1:0]   ahb_speed,
  input  logic [ST_RATIO_W-1:0] cpu_ratio,
  output logic [DATA_W-1:0]     status_word
);
  logic                  xtal_q;
  logic [ST_AHB_W-1:0]   ahb_q;
  logic [ST_RATIO_W-1:0] ratio_q;

  // straps are sampled only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      xtal_q  <= xtal_half;
      ahb_q   <= ahb_speed;
      ratio_q <= cpu_ratio;
    end
  end

  always_comb begin
    status_word = '0;
    status_word[ST_XTAL_BIT] = xtal_q;
    status_word[ST_AHB_LSB +: ST_AHB_W] = ahb_q;
    status_word[ST_RATIO_LSB +: ST_RATIO_W] = ratio_q;
  end
endmodule

// File: rtl/sys_ctl_regs.sv
module sys_ctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_RST   = 32,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic                  strap_xtal_half,
  input  logic [2:0]            strap_ahb_speed,
  input  logic [1:0]            strap_cpu_ratio,
  output logic [NUM_RST-1:0]    srst_out,
  output logic [12:0]           gate_off,
  output logic                  clkrun_en,
  output logic [4:0]            tv_half_div,
  output logic                  sec_clk_full,
  output logic                  pci_clk_fast
);
  localparam int unsigned RST_USED = (NUM_RST < DATA_W) ? NUM_RST : DATA_W;

  logic hit_status, hit_srst, hit_misc, hit_clk;
  logic [DATA_W-1:0] clk_q, misc_q, status_w, srst_w, rd_mux, rdata_q;

  assign hit_status = (bus_addr == ADDR_W'(OFS_STATUS));
  assign hit_srst   = (bus_addr == ADDR_W'(OFS_SRST));
  assign hit_misc   = (bus_addr == ADDR_W'(OFS_MISC));
  assign hit_clk    = (bus_addr == ADDR_W'(OFS_CLK));

  // one self-timed pulse generator per reset line
  for (genvar i = 0; i < NUM_RST; i++) begin : g_line
    if (i < DATA_W) begin : g_mapped
      srst_pulse_ctr #(.PULSE_LEN(PULSE_LEN)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .start  (bus_wr && hit_srst && bus_wdata[i]),
        .active (srst_out[i])
      );
    end else begin : g_unmapped
      assign srst_out[i] = 1'b0;
    end
  end

  always_comb begin
    srst_w = '0;
    srst_w[RST_USED-1:0] = srst_out[RST_USED-1:0];
  end

  masked_ctl_reg #(.W(DATA_W), .MASK(CLK_MASK), .RST_VAL('0)) u_clk_reg (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_wr && hit_clk),
    .wdata (bus_wdata),
    .q     (clk_q)
  );

  masked_ctl_reg #(.W(DATA_W), .MASK(MISC_MASK), .RST_VAL('0)) u_misc_reg (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_wr && hit_misc),
    .wdata (bus_wdata),
    .q     (misc_q)
  );

  strap_status u_status (
    .clk         (clk),
    .rst         (rst),
    .xtal_half   (strap_xtal_half),
    .ahb_speed   (strap_ahb_speed),
    .cpu_ratio   (strap_cpu_ratio),
    .status_word (status_w)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_status) rd_mux = status_w;
    if (hit_srst)   rd_mux = srst_w;
    if (hit_misc)   rd_mux = misc_q;
    if (hit_clk)    rd_mux = clk_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata    = rdata_q;
  assign gate_off     = clk_q[GATE_LSB +: GATE_NUM];
  assign clkrun_en    = clk_q[CLKRUN_BIT];
  assign tv_half_div  = clk_q[TVDIV_LSB +: TVDIV_W];
  assign sec_clk_full = clk_q[SECSEL_BIT];
  assign pci_clk_fast = misc_q[PCI66_BIT];
endmodule

// File: rtl/sys_ctl_regs_chk.sv
module sys_ctl_regs_chk
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_RST   = 32,
  parameter int unsigned PULSE_LEN = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NUM_RST-1:0] srst_out,
  input logic [12:0]        gate_off,
  input logic               pci_clk_fast
);
  localparam int unsigned SW = $clog2(PULSE_LEN + 2);

  logic unmapped;
  assign unmapped = (bus_addr != ADDR_W'(OFS_STATUS)) && (bus_addr != ADDR_W'(OFS_SRST)) &&
                    (bus_addr != ADDR_W'(OFS_MISC))   && (bus_addr != ADDR_W'(OFS_CLK));

  for (genvar i = 0; i < NUM_RST && i < 32; i++) begin : g_line
    logic [SW-1:0] since_q;
    logic          st;
    assign st = bus_wr && (bus_addr == ADDR_W'(OFS_SRST)) && bus_wdata[i];

    always_ff @(posedge clk) begin
      if (rst)                           since_q <= SW'(PULSE_LEN);
      else if (st)                       since_q <= '0;
      else if (since_q != SW'(PULSE_LEN)) since_q <= since_q + 1'b1;
    end

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
      srst_out[i] |-> (since_q < SW'(PULSE_LEN))); // R2
    AST_PULSE_HELD: assert property (@(posedge clk) disable iff (rst)
      (since_q < SW'(PULSE_LEN)) |-> srst_out[i]); // R4
  end

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == ADDR_W'(OFS_CLK)) |=> $stable(gate_off)); // R7
  AST_PCI_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == ADDR_W'(OFS_MISC)) |=> $stable(pci_clk_fast)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && unmapped) |=> (bus_rdata == 32'h0)); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R5
endmodule

bind sys_ctl_regs sys_ctl_regs_chk #(.ADDR_W(ADDR_W), .NUM_RST(NUM_RST), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .srst_out     (srst_out),
  .gate_off     (gate_off),
  .pci_clk_fast (pci_clk_fast)
);

// File: tb/tb_sys_ctl_regs.sv
`timescale 1ns/1ps
module tb_sys_ctl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        strap_xtal_half = 1'b1;
  logic [2:0]  strap_ahb_speed = 3'd5;
  logic [1:0]  strap_cpu_ratio = 2'd2;
  logic [31:0] srst_out;
  logic [12:0] gate_off;
  logic        clkrun_en, sec_clk_full, pci_clk_fast;
  logic [4:0]  tv_half_div;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sys_ctl_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strap_xtal_half(strap_xtal_half),
    .strap_ahb_speed(strap_ahb_speed), .strap_cpu_ratio(strap_cpu_ratio),
    .srst_out(srst_out), .gate_off(gate_off), .clkrun_en(clkrun_en),
    .tv_half_div(tv_half_div), .sec_clk_full(sec_clk_full), .pci_clk_fast(pci_clk_fast)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h34, 32'hFFFF_FFFF, 32'h0, 4'd8},          // R8 write all ones
    '{1'b0, 8'h34, 32'h0, 32'h3F01_3FFE, 4'd8},          // R8 only fields kept
    '{1'b1, 8'h34, 32'h0000_0C00, 32'h0, 4'd7},          // R7 memory/flash gates
    '{1'b0, 8'h34, 32'h0, 32'h0000_0C00, 4'd7},
    '{1'b1, 8'h30, 32'hFFFF_FFFF, 32'h0, 4'd9},          // R9
    '{1'b0, 8'h30, 32'h0, 32'h0004_0000, 4'd9},
    '{1'b1, 8'h30, 32'h0, 32'h0, 4'd9},
    '{1'b0, 8'h30, 32'h0, 32'h0, 4'd9},
    '{1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0, 4'd10},         // R10 write ignored
    '{1'b0, 8'h04, 32'h0, 32'h400A_8000, 4'd10},
    '{1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0, 4'd11},         // R11
    '{1'b0, 8'h08, 32'h0, 32'h0, 4'd11},
    '{1'b0, 8'h34, 32'h0, 32'h0000_0C00, 4'd11},         // R11 unmapped write left clk reg
    '{1'b0, 8'h3C, 32'h0, 32'h0, 4'd11},
    '{1'b0, 8'h0D, 32'h0, 32'h0, 4'd11},                 // R11 misaligned
    '{1'b1, 8'h34, 32'h0, 32'h0, 4'd7}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // counts falling-edge observations while the line stays high
  task automatic pulse_len(input int b, output int n);
    n = 0;
    while (srst_out[b] && n < 64) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", srst_out, 32'h0);
    chk("R1", {19'h0, gate_off}, 32'h0);
    chk("R1", {25'h0, clkrun_en, sec_clk_full, tv_half_div}, 32'h0);
    chk("R1", {31'h0, pci_clk_fast}, 32'h0);
    chk("R1", bus_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, d);
        n_chk++;
        if (d !== VECS[i].exp) begin
          n_fail++;
          $display("FAIL R%0d: vector %0d actual %h expected %h", VECS[i].rq, i, d, VECS[i].exp);
        end
      end
    end

    // R10 strap changes after reset are not seen
    strap_xtal_half = 1'b0; strap_ahb_speed = 3'd0; strap_cpu_ratio = 2'd0;
    rd(8'h04, d);
    chk("R10", d, 32'h400A_8000);

    // R2 single line pulse length and isolation
    wr(8'h0C, 32'h0000_0100);
    chk("R2", srst_out, 32'h0000_0100);
    pulse_len(8, n);
    chk("R2", n, 16);
    chk("R2", srst_out, 32'h0);

    // R5 read shows pulses in flight
    wr(8'h0C, 32'h0000_0005);
    rd(8'h0C, d);
    chk("R5", d, 32'h0000_0005);
    pulse_len(0, n);
    chk("R5", n, 15);
    rd(8'h0C, d);
    chk("R5", d, 32'h0);

    // R3 restart
    wr(8'h0C, 32'h0000_0001);
    repeat (10) @(negedge clk);
    wr(8'h0C, 32'h0000_0001);
    pulse_len(0, n);
    chk("R3", n, 16);

    // R4 zero write neither stops nor extends
    wr(8'h0C, 32'h0000_0008);
    repeat (3) @(negedge clk);
    wr(8'h0C, 32'h0000_0000);
    chk("R4", srst_out, 32'h0000_0008);
    pulse_len(3, n);
    chk("R4", n, 12);

    // R6 second-processor bit alongside a running line
    wr(8'h0C, 32'h4000_0002);
    chk("R6", srst_out, 32'h4000_0002);
    repeat (5) @(negedge clk);
    wr(8'h0C, 32'h4000_0000);
    chk("R6", srst_out, 32'h4000_0002);
    pulse_len(1, n);
    chk("R6", n, 10);
    chk("R6", srst_out, 32'h4000_0000);
    repeat (20) @(negedge clk);

    // R7 gate outputs, set-to-disable
    wr(8'h34, 32'h0000_2002);
    chk("R7", {19'h0, gate_off}, 32'h0000_1001);
    // R8 option fields
    wr(8'h34, 32'h3A01_0000);
    chk("R8", {19'h0, gate_off}, 32'h0);
    chk("R8", {25'h0, clkrun_en, sec_clk_full, tv_half_div}, {25'h0, 1'b1, 1'b1, 5'h1A});
    wr(8'h34, 32'h0001_0000);
    chk("R8", {25'h0, clkrun_en, sec_clk_full, tv_half_div}, {25'h0, 1'b1, 1'b0, 5'h00});
    // R9 PCI speed select
    wr(8'h30, 32'h0004_0000);
    chk("R9", {31'h0, pci_clk_fast}, 32'h1);
    wr(8'h30, 32'hFFFB_FFFF);
    chk("R9", {31'h0, pci_clk_fast}, 32'h0);

    // R1 mid-run reset clears gates and cancels pulses
    wr(8'h34, 32'h0000_3FFE);
    wr(8'h30, 32'h0004_0000);
    wr(8'h0C, 32'hFFFF_FFFF);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", srst_out, 32'h0);
    chk("R1", {19'h0, gate_off}, 32'h0);
    chk("R1", {31'h0, pci_clk_fast}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule